// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block gives every CPU a single-slot mailbox for interrupt messages that arrive from an external system bus. Each message names a target CPU and carries a source identifier and two 64-bit payload words. When the target slot is empty, the block takes the message, marks the slot occupied and, one cycle later, raises an interrupt post toward that CPU. The post carries one vector that all slots share and that software programs. When the slot is still occupied, the block turns the message away in the same cycle, and the sender must try again later.

Software reaches the mailboxes through a simple register port with a combinational read path. Three indexed windows expose payload word 0, payload word 1 and the status of every slot. A small alias area exposes the same three views for the CPU that issues the access, plus the shared vector register. Software frees a slot by writing zero to the occupied bit of its status word.

Top module: `bus_irq_mailbox`

## Requirements
- R1: After reset, every slot is free, the vector register holds 0, no interrupt is posted, and every status and payload read returns 0.
- R2: A valid message whose target slot is free raises `msg_accept` and keeps `msg_reject` low in the same cycle it is presented. Exactly one of the two is high whenever `msg_valid` is high, and neither is high otherwise.
- R3: An accepted message stores its source ID and both payload words in the target slot and sets the slot busy. Byte offset 0x000 + 8*n reads word 0 of slot n, 0x100 + 8*n reads word 1, and 0x200 + 8*n reads status. Status has busy at bit 5 and the source ID in bits 4:0, with all other bits 0.
- R4: The cycle after an accept, `irq_valid` is high for one cycle, with `irq_cpu` set to the target and `irq_vec` set to the vector register value from the accept cycle. `irq_valid` is never high otherwise.
- R5: A message aimed at a busy slot is rejected. It leaves the slot's stored source and payload unchanged and posts no interrupt.
- R6: A write to offset 0x318 loads the vector register from write data bits 5:0. The other bits are ignored, and a read of 0x318 returns the vector in bits 5:0.
- R7: A write to a status address loads the busy bit from write data bit 5. Writing 0 frees the slot and writing 1 marks it busy. The stored source ID is not altered by such a write.
- R8: The alias offsets 0x300 (word 0), 0x308 (word 1) and 0x310 (status) access the slot selected by `reg_cpu`, the requester's CPU ID, for both reads and status writes.
- R9: When a status write that frees slot n and a message for slot n occur in the same cycle, the release applies first and the message is accepted.
- R10: Payload addresses are read-only, so writes there change nothing. Offsets from 0x320 upward read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Incoming bus message present this cycle |
| msg_cpu | input | 5 | Target CPU of the message |
| msg_src | input | 5 | Source identifier of the message |
| msg_d0 | input | 64 | Payload word 0 |
| msg_d1 | input | 64 | Payload word 1 |
| msg_accept | output | 1 | Message taken this cycle |
| msg_reject | output | 1 | Message refused this cycle; the sender retries |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset (bits 2:0 ignored) |
| reg_wdata | input | 64 | Register write data |
| reg_cpu | input | 5 | CPU ID of the requester, used by alias offsets |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| irq_valid | output | 1 | One-cycle interrupt post |
| irq_cpu | output | 5 | CPU the interrupt is posted to |
| irq_vec | output | 6 | Vector delivered with the post |

## Verification
Several properties are checked on every cycle. The accept/reject response is always exclusive and always matches `msg_valid`. A busy slot that is not being released always refuses messages. Every interrupt post follows an accept by exactly one cycle and carries that accept's target and vector. The contents of an occupied slot stay put while no release is under way. Some behaviour can only be shown through the bench's scenarios. These are the address map with its alias resolution through `reg_cpu`, the bit layouts of the status and vector registers, the release-then-accept ordering in a shared cycle, and the read-only and unmapped regions.

// File: rtl/mbx_pkg.sv
// Shared definitions for the bus interrupt mailbox.
// Assumes: status layout fixes busy at bit 5, with the source ID below it.
package mbx_pkg;
    localparam int BUSY_BIT = 5;

    // Which register a decoded access touches.
    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_D0,
        FLD_D1,
        FLD_STAT,
        FLD_VEC
    } fld_e;
endpackage

// File: rtl/mbx_addr_decode.sv
// Decodes a register offset into a field kind and a slot index.
// The first three windows are indexed by offset>>3. The fourth window holds
// aliases that resolve to the requester's slot, then the vector register.
// Assumes NUM_CPU >= 4 so that the alias slots fit in the index field.
module mbx_addr_decode
    import mbx_pkg::*;
#(
    parameter int NUM_CPU = 32,
    localparam int IDX_W = $clog2(NUM_CPU),
    localparam int WIN_SHIFT = IDX_W + 3,
    localparam int ADDR_W = WIN_SHIFT + 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  req_cpu_i,
    output fld_e              fld_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [1:0]       region;
    logic [IDX_W-1:0] slot;
    fld_e             fld_raw;

    assign region = addr_i[WIN_SHIFT+1:WIN_SHIFT];
    assign slot   = addr_i[WIN_SHIFT-1:3];

    // Map the region and slot to a raw field and index.
    always_comb begin
        fld_raw = FLD_NONE;
        idx_o   = slot;
        unique case (region)
            2'd0: fld_raw = FLD_D0;
            2'd1: fld_raw = FLD_D1;
            2'd2: fld_raw = FLD_STAT;
            default: begin
                idx_o = req_cpu_i;
                if (slot == IDX_W'(0))      fld_raw = FLD_D0;
                else if (slot == IDX_W'(1)) fld_raw = FLD_D1;
                else if (slot == IDX_W'(2)) fld_raw = FLD_STAT;
                else if (slot == IDX_W'(3)) fld_raw = FLD_VEC;
            end
        endcase
    end

    // Drop slot accesses whose index has no mailbox behind it.
    always_comb begin
        fld_o = fld_raw;
        if (fld_raw != FLD_VEC && 32'(idx_o) >= NUM_CPU)
            fld_o = FLD_NONE;
    end
endmodule

// File: rtl/mbx_slot.sv
// One CPU's mailbox slot: busy flag, source ID and two payload words.
// A capture has priority over a release, because the top only captures
// when free_o is high, and free_o already accounts for a release this cycle.
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SRC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [DATA_W-1:0] d0_i,
    input  logic [DATA_W-1:0] d1_i,
    input  logic              rel_we_i,
    input  logic              rel_busy_i,
    output logic              free_o,
    output logic              busy_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [DATA_W-1:0] d0_o,
    output logic [DATA_W-1:0] d1_o
);
    logic busy_q;

    // Effective occupancy after any status write in this cycle.
    assign free_o = rel_we_i ? !rel_busy_i : !busy_q;
    assign busy_o = busy_q;

    // Busy flag: set by a capture, otherwise loaded by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (cap_i)    busy_q <= 1'b1;
        else if (rel_we_i) busy_q <= rel_busy_i;
    end

    // Message contents: loaded only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_o <= '0;
            d0_o  <= '0;
            d1_o  <= '0;
        end else if (cap_i) begin
            src_o <= src_i;
            d0_o  <= d0_i;
            d1_o  <= d1_i;
        end
    end

    AST_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !rel_we_i |=> $stable(d0_o) && $stable(d1_o) && $stable(src_o)); // R5
endmodule

// File: rtl/bus_irq_mailbox.sv
// Per-CPU bus interrupt mailbox. Each message is accepted or rejected in the
// cycle it is presented, and an accept posts an interrupt one cycle later
// with the shared vector. The register port reads combinationally.
// Assumes the sender holds off a rejected message and retries later.
module bus_irq_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_CPU = 32,
    parameter int DATA_W  = 64,
    parameter int SRC_W   = 5,
    parameter int VEC_W   = 6,
    localparam int IDX_W = $clog2(NUM_CPU),
    localparam int ADDR_W = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [IDX_W-1:0]  msg_cpu,
    input  logic [SRC_W-1:0]  msg_src,
    input  logic [DATA_W-1:0] msg_d0,
    input  logic [DATA_W-1:0] msg_d1,
    output logic              msg_accept,
    output logic              msg_reject,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [IDX_W-1:0]  reg_cpu,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_valid,
    output logic [IDX_W-1:0]  irq_cpu,
    output logic [VEC_W-1:0]  irq_vec
);
    fld_e              fld;
    logic [IDX_W-1:0]  idx;
    logic [VEC_W-1:0]  vec_q;
    logic [NUM_CPU-1:0] free_v, busy_v, cap_v, rel_v;
    logic [SRC_W-1:0]  src_a [NUM_CPU];
    logic [DATA_W-1:0] d0_a  [NUM_CPU];
    logic [DATA_W-1:0] d1_a  [NUM_CPU];
    logic              tgt_free, tgt_busy;
    logic              sel_busy;
    logic [SRC_W-1:0]  sel_src;
    logic [DATA_W-1:0] sel_d0, sel_d1;

    mbx_addr_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .addr_i   (reg_addr),
        .req_cpu_i(reg_cpu),
        .fld_o    (fld),
        .idx_o    (idx)
    );

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
        assign cap_v[g] = msg_accept && (msg_cpu == IDX_W'(g));
        assign rel_v[g] = reg_we && (fld == FLD_STAT) && (idx == IDX_W'(g));
        mbx_slot #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap_i     (cap_v[g]),
            .src_i     (msg_src),
            .d0_i      (msg_d0),
            .d1_i      (msg_d1),
            .rel_we_i  (rel_v[g]),
            .rel_busy_i(reg_wdata[BUSY_BIT]),
            .free_o    (free_v[g]),
            .busy_o    (busy_v[g]),
            .src_o     (src_a[g]),
            .d0_o      (d0_a[g]),
            .d1_o      (d1_a[g])
        );
    end

    // Look up the message target's occupancy (out-of-range targets stay busy).
    always_comb begin
        tgt_free = 1'b0;
        tgt_busy = 1'b0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (msg_cpu == IDX_W'(i)) begin
                tgt_free = free_v[i];
                tgt_busy = busy_v[i];
            end
        end
    end

    // Same-cycle accept/reject response to the sender.
    assign msg_accept = msg_valid && tgt_free;
    assign msg_reject = msg_valid && !tgt_free;

    // Shared vector register, written from data bits 5:0.
    always_ff @(posedge clk) begin
        if (!rst_n)                      vec_q <= '0;
        else if (reg_we && fld == FLD_VEC) vec_q <= reg_wdata[VEC_W-1:0];
    end

    // Interrupt post, one cycle after the accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_cpu   <= '0;
            irq_vec   <= '0;
        end else begin
            irq_valid <= msg_accept;
            irq_cpu   <= msg_cpu;
            irq_vec   <= vec_q;
        end
    end

    // Select the addressed slot's contents for the read path.
    always_comb begin
        sel_busy = 1'b0;
        sel_src  = '0;
        sel_d0   = '0;
        sel_d1   = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_busy = busy_v[i];
                sel_src  = src_a[i];
                sel_d0   = d0_a[i];
                sel_d1   = d1_a[i];
            end
        end
    end

    // Format the read data by field.
    always_comb begin
        reg_rdata = '0;
        case (fld)
            FLD_D0:   reg_rdata = sel_d0;
            FLD_D1:   reg_rdata = sel_d1;
            FLD_STAT: begin
                reg_rdata[BUSY_BIT]  = sel_busy;
                reg_rdata[SRC_W-1:0] = sel_src;
            end
            FLD_VEC:  reg_rdata[VEC_W-1:0] = vec_q;
            default:  reg_rdata = '0;
        endcase
    end

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({msg_accept, msg_reject}) == (msg_valid ? 1 : 0)); // R2
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && tgt_busy && !(reg_we && fld == FLD_STAT && idx == msg_cpu)
        |-> msg_reject); // R5
    AST_POST_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        msg_accept |=> irq_valid && irq_cpu == $past(msg_cpu) && irq_vec == $past(vec_q)); // R4
    AST_POST_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(msg_accept)); // R4
endmodule

// File: tb/bus_irq_mailbox_bench.sv
`timescale 1ns/1ps
module bus_irq_mailbox_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [4:0]  msg_cpu = '0;
    logic [4:0]  msg_src = '0;
    logic [63:0] msg_d0 = '0;
    logic [63:0] msg_d1 = '0;
    logic        msg_accept, msg_reject;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [4:0]  reg_cpu = '0;
    logic [63:0] reg_rdata;
    logic        irq_valid;
    logic [4:0]  irq_cpu;
    logic [5:0]  irq_vec;

    int checks = 0;
    int fails  = 0;
    logic [5:0]  exp_vec = '0;
    logic [10:0] irq_q[$];   // {cpu, vector} expected posts
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    bus_irq_mailbox u_bus_irq_mailbox (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_cpu(msg_cpu), .msg_src(msg_src),
        .msg_d0(msg_d0), .msg_d1(msg_d1),
        .msg_accept(msg_accept), .msg_reject(msg_reject),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_cpu(reg_cpu), .reg_rdata(reg_rdata),
        .irq_valid(irq_valid), .irq_cpu(irq_cpu), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input bit ok,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        msg_valid = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clear_inputs();
        end
    endtask

    // Driver: present one message, check the response, queue the expected post.
    task automatic send(input string req, input logic [4:0] cpu, input logic [4:0] src,
                        input logic [63:0] d0, input logic [63:0] d1, input bit exp_acc);
        @(negedge clk);
        clear_inputs();
        msg_valid = 1'b1; msg_cpu = cpu; msg_src = src; msg_d0 = d0; msg_d1 = d1;
        #1;
        check(req, msg_accept == exp_acc && msg_reject == !exp_acc,
              {62'd0, msg_accept, msg_reject}, {62'd0, exp_acc, !exp_acc});
        if (exp_acc) irq_q.push_back({cpu, exp_vec});
    endtask

    task automatic wr(input logic [9:0] addr, input logic [63:0] data, input logic [4:0] rcpu);
        @(negedge clk);
        clear_inputs();
        reg_we = 1'b1; reg_addr = addr; reg_wdata = data; reg_cpu = rcpu;
    endtask

    task automatic rd(input string req, input logic [9:0] addr, input logic [4:0] rcpu,
                      input logic [63:0] exp);
        @(negedge clk);
        clear_inputs();
        reg_addr = addr; reg_cpu = rcpu;
        #1;
        check(req, reg_rdata == exp, reg_rdata, exp);
    endtask

    // Release by status write and a message for the same slot in one cycle.
    task automatic send_with_release(input string req, input logic [4:0] cpu,
                                     input logic [4:0] src, input logic [63:0] d0,
                                     input logic [63:0] d1);
        @(negedge clk);
        clear_inputs();
        msg_valid = 1'b1; msg_cpu = cpu; msg_src = src; msg_d0 = d0; msg_d1 = d1;
        reg_we = 1'b1; reg_addr = 10'h200 + 10'(cpu) * 10'd8; reg_wdata = 64'h0; reg_cpu = '0;
        #1;
        check(req, msg_accept && !msg_reject, {62'd0, msg_accept, msg_reject}, 64'h2);
        irq_q.push_back({cpu, exp_vec});
    endtask

    // Monitor: every post must match the next expected item (R4).
    always @(negedge clk) begin
        if (rst_n && irq_valid) begin
            if (irq_q.size() == 0) begin
                check("R4 unexpected post", 1'b0, {53'd0, irq_cpu, irq_vec}, 64'h0);
            end else begin
                logic [10:0] e;
                e = irq_q.pop_front();
                check("R4 post", {irq_cpu, irq_vec} == e, {53'd0, irq_cpu, irq_vec}, {53'd0, e});
            end
        end
    end

    // Watchdog.
    initial begin
        #500000;
        if (!done) begin
            check("watchdog", 1'b0, 64'h0, 64'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 no post after reset", irq_valid == 1'b0, {63'd0, irq_valid}, 64'h0);
        rd("R1 status 0", 10'h200, 5'd0, 64'h0);
        rd("R1 status 31", 10'h2F8, 5'd0, 64'h0);
        rd("R1 word0 slot 5", 10'h028, 5'd0, 64'h0);
        rd("R1 vector", 10'h318, 5'd0, 64'h0);

        // R6 vector register
        wr(10'h318, 64'h2A, 5'd0); exp_vec = 6'h2A;
        rd("R6 vector readback", 10'h318, 5'd0, 64'h2A);
        wr(10'h318, 64'hFFFF_FFC0_0000_0FD5, 5'd0); exp_vec = 6'h15;
        rd("R6 upper bits ignored", 10'h318, 5'd0, 64'h15);

        // R2 R3 accept and storage
        send("R2 accept free slot 3", 5'd3, 5'd7, 64'hA0A0_0000_1111_0003, 64'hB0B0_0000_2222_0003, 1'b1);
        idle(1);
        rd("R3 word0 slot 3", 10'h018, 5'd0, 64'hA0A0_0000_1111_0003);
        rd("R3 word1 slot 3", 10'h118, 5'd0, 64'hB0B0_0000_2222_0003);
        rd("R3 status slot 3", 10'h218, 5'd0, 64'h27);

        // R5 busy slot refuses, contents kept, no post
        send("R5 reject busy slot 3", 5'd3, 5'd9, 64'h1, 64'h2, 1'b0);
        idle(2);
        rd("R5 word0 unchanged", 10'h018, 5'd0, 64'hA0A0_0000_1111_0003);
        rd("R5 status unchanged", 10'h218, 5'd0, 64'h27);

        send("R2 accept slot 31", 5'd31, 5'd31, 64'hC31, 64'hD31, 1'b1);
        idle(1);
        rd("R3 status slot 31", 10'h2F8, 5'd0, 64'h3F);

        // R8 alias views
        rd("R8 alias word0 cpu3", 10'h300, 5'd3, 64'hA0A0_0000_1111_0003);
        rd("R8 alias word1 cpu3", 10'h308, 5'd3, 64'hB0B0_0000_2222_0003);
        rd("R8 alias status cpu3", 10'h310, 5'd3, 64'h27);
        rd("R8 alias word0 cpu31", 10'h300, 5'd31, 64'hC31);
        rd("R8 alias status idle cpu4", 10'h310, 5'd4, 64'h0);

        // R7 release through the alias, source kept
        wr(10'h310, 64'h0, 5'd3);
        rd("R7 released keeps source", 10'h218, 5'd0, 64'h07);
        send("R7 accept after release", 5'd3, 5'd2, 64'h33, 64'h44, 1'b1);
        idle(1);
        wr(10'h218, 64'h1F, 5'd0);
        rd("R7 bit5 clear frees, low bits ignored", 10'h218, 5'd0, 64'h02);
        wr(10'h218, 64'h20, 5'd0);
        rd("R7 bit5 set marks busy", 10'h218, 5'd0, 64'h22);
        send("R7 set busy refuses", 5'd3, 5'd1, 64'h5, 64'h6, 1'b0);

        // R9 release and message in the same cycle
        send_with_release("R9 same-cycle release accepts", 5'd31, 5'd4, 64'hE1, 64'hE2);
        idle(1);
        rd("R9 new word0", 10'h0F8, 5'd0, 64'hE1);
        rd("R9 busy with new source", 10'h2F8, 5'd0, 64'h24);

        // R10 read-only and unmapped space
        wr(10'h0F8, 64'hDEAD, 5'd0);
        rd("R10 word0 write ignored", 10'h0F8, 5'd0, 64'hE1);
        wr(10'h320, 64'h3F, 5'd0);
        rd("R10 unmapped reads 0", 10'h320, 5'd0, 64'h0);
        rd("R10 vector untouched", 10'h318, 5'd0, 64'h15);
        rd("R10 high unmapped reads 0", 10'h3F8, 5'd0, 64'h0);

        idle(3);
        check("R4 all posts seen", irq_q.size() == 0, 64'(irq_q.size()), 64'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule